// File: doc/BRIEF.md
# I/O Port Test-and-Flag Unit

This block carries out one test of an I/O port byte for an 8-bit CPU datapath whose address bus is 24 bits wide. When the sequencer pulses `start`, the block captures the C register value and an 8-bit immediate mask. It then issues a single I/O read at an address whose low byte is C and whose upper bits are zero.

When the port signals ready, the block ANDs the returned byte with the mask. It uses that result only to set the arithmetic flags and keeps no other copy of it. Once the flags are updated, a one-clock `done` pulse tells the sequencer that the operation has finished.

A zero-wait port completes the read on the first clock edge after the one that accepted `start`. Each clock during which `io_ready` stays low adds one cycle to the operation.

Top module: `io_probe_flags`

## Requirements
- R1: `io_addr[7:0]` equals the `c_reg` value sampled on the clock edge that accepted `start`, and `io_addr[23:8]` is always zero.
- R2: `io_rd` goes high on the edge that accepts `start`. It stays high through every edge on which `io_ready` is low and drops on the first edge on which `io_ready` is high.
- R3: Flag bit 7 (sign) is set to bit 7 of `io_din & mask`. Flag bit 6 (zero) is set exactly when that result is 0x00.
- R4: Flag bit 2 (parity) is set when the result has an even number of one bits and cleared when the count is odd.
- R5: Every completed operation writes flag bit 4 (half-carry) to 1, flag bit 1 (subtract) to 0 and flag bit 0 (carry) to 0.
- R6: Reserved flag bits 5 and 3 keep their previous value and therefore remain 0 after reset.
- R7: The flags change only on the edge that captures `io_din`. On that same edge `done` is set, and it stays high for exactly one clock.
- R8: A `start` that arrives while a read is in progress is ignored. It neither re-latches `c_reg` or `mask` nor causes a second read. A `start` in the `done` cycle is accepted.
- R9: While `rst_n` is low, `io_rd`, `done`, `flags` and `io_addr` are all zero.
- R10: `mask` and `c_reg` matter only on the accepting edge. Changing them afterwards does not affect the address or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test operation |
| mask | input | 8 | Immediate mask operand |
| c_reg | input | 8 | C register value used as the port number |
| io_addr | output | ADDR_W | I/O address |
| io_rd | output | 1 | I/O read strobe |
| io_ready | input | 1 | Port data valid; ends the read |
| io_din | input | 8 | Data returned by the port |
| flags | output | 8 | Flag byte: S=7, Z=6, H=4, P/V=2, N=1, C=0 |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench instantiates the block with its default `ADDR_W` of 24. That gives 16 forced-zero address bits, so any leak of C or of stale state into the upper bits appears at once.

Directed operations cover these cases:
- results of zero, 0x80 and 0xFF;
- results with odd and with even parity;
- port wait states of several lengths;
- `start` pulses during a read;
- a back-to-back start in the `done` cycle.

These are followed by a long run with random operands and random ready timing.

// File: rtl/io_probe_flags.sv
module io_probe_flags #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        mask,
  input  logic [7:0]        c_reg,
  output logic [ADDR_W-1:0] io_addr,
  output logic              io_rd,
  input  logic              io_ready,
  input  logic [7:0]        io_din,
  output logic [7:0]        flags,
  output logic              done
);
  localparam int HI_W = ADDR_W - 8;

  logic       busy;
  logic       done_q;
  logic [7:0] port_q;
  logic [7:0] mask_q;
  logic [7:0] flags_q;

  wire [7:0] res  = io_din & mask_q;
  wire       take = busy & io_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      port_q  <= '0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      done_q <= take;
      if (take) begin
        busy    <= 1'b0;
        flags_q <= {res[7], (res == 8'h00), flags_q[5], 1'b1,
                    flags_q[3], ~^res, 1'b0, 1'b0};
      end else if (!busy && start) begin
        busy   <= 1'b1;
        port_q <= c_reg;
        mask_q <= mask;
      end
    end
  end

  assign io_addr = {{HI_W{1'b0}}, port_q};
  assign io_rd   = busy;
  assign flags   = flags_q;
  assign done    = done_q;
endmodule

module io_probe_flags_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_ready,
  input logic [7:0]        flags,
  input logic              done
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    io_addr[ADDR_W-1:8] == '0);
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_ready) |=> io_rd);
  a_r7_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_ready) |=> (done && !io_rd));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_ready) |=> $stable(flags));
  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[4] && !flags[1] && !flags[0]));
  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[5] && !flags[3]);
  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> $stable(io_addr));
endmodule

bind io_probe_flags io_probe_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
  .io_ready(io_ready), .flags(flags), .done(done));

// File: tb/io_probe_flags_bench.sv
module io_probe_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mask = '0;
  logic [7:0] c_reg = '0;
  logic io_ready = 1'b0;
  logic [7:0] io_din = '0;
  logic [ADDR_W-1:0] io_addr;
  logic io_rd;
  logic [7:0] flags;
  logic done;

  int compared = 0;
  int mismatched = 0;

  bit m_busy = 0, m_done = 0;
  logic [7:0] m_c = 0, m_mask = 0, m_flags = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_probe_flags #(.ADDR_W(ADDR_W)) u_io_probe_flags (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .c_reg(c_reg),
    .io_addr(io_addr), .io_rd(io_rd), .io_ready(io_ready), .io_din(io_din),
    .flags(flags), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [7:0] r;
    int ones;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_c = 0; m_mask = 0; m_flags = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (io_ready) begin
          r = io_din & m_mask;
          ones = 0;
          for (int i = 0; i < 8; i++) if (r[i]) ones++;
          m_flags[7] = r[7];
          m_flags[6] = (r == 0);
          m_flags[4] = 1'b1;
          m_flags[2] = (ones % 2 == 0);
          m_flags[1] = 1'b0;
          m_flags[0] = 1'b0;
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        m_busy = 1; m_c = c_reg; m_mask = mask;
      end
    end
  endtask

  task automatic compare_all();
    logic [ADDR_W-1:0] ea;
    ea = {{(ADDR_W-8){1'b0}}, m_c};
    chk(io_addr === ea, "R1 io_addr", 32'(io_addr), 32'(ea));
    chk(io_rd === m_busy, "R2/R8 io_rd", 32'(io_rd), 32'(m_busy));
    chk(flags[7:6] === m_flags[7:6], "R3 S/Z", 32'(flags), 32'(m_flags));
    chk(flags[2] === m_flags[2], "R4 parity", 32'(flags), 32'(m_flags));
    chk(flags[4] === m_flags[4] && flags[1:0] === m_flags[1:0], "R5 H/N/C", 32'(flags), 32'(m_flags));
    chk(flags[5] === m_flags[5] && flags[3] === m_flags[3], "R6 reserved", 32'(flags), 32'(m_flags));
    chk(done === m_done, "R7 done", 32'(done), 32'(m_done));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_op(input logic [7:0] c, input logic [7:0] m, input logic [7:0] d,
                        input int waits, input bit poke);
    start = 1; c_reg = c; mask = m; io_ready = 0;
    step();
    start = 0; c_reg = ~c; mask = ~m;  // R10: late operand changes
    for (int i = 0; i < waits; i++) begin
      io_ready = 0; io_din = 8'($urandom);
      start = poke;  // R8: start during a read
      c_reg = 8'($urandom); mask = 8'($urandom);
      step();
    end
    start = 0; io_ready = 1; io_din = d;
    step();
    io_ready = 0;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    compare_all();  // R9 reset state
    step();
    rst_n = 1;
    step();
    run_op(8'h12, 8'hF0, 8'h0F, 0, 0);  // R3 zero result
    run_op(8'hFE, 8'h80, 8'hFF, 2, 0);  // R3 sign, R4 odd parity
    run_op(8'h00, 8'hFF, 8'hFF, 1, 1);  // R4 even parity, R8 pokes
    run_op(8'hFF, 8'h03, 8'h03, 3, 1);  // R4 even
    run_op(8'h5A, 8'h01, 8'h01, 0, 0);  // R4 odd
    // R8: start in done cycle accepted
    start = 1; c_reg = 8'h33; mask = 8'h3C; step();
    start = 0; io_ready = 1; io_din = 8'h24; step();
    start = 1; c_reg = 8'hC7; mask = 8'hAA; io_ready = 0; step();
    start = 0; io_ready = 1; io_din = 8'hA8; step();
    io_ready = 0; step();
    for (int k = 0; k < 300; k++) begin
      start = ($urandom % 3) != 0;
      c_reg = 8'($urandom); mask = 8'($urandom);
      io_ready = ($urandom % 2) != 0; io_din = 8'($urandom);
      step();
    end
    start = 0; io_ready = 0;
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule